// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Unit

This block decides, every cycle, whether the front of a five-stage in-order integer pipeline must hold still. It looks at the two source register numbers of the instruction in decode and at a flag that marks that instruction as a branch. It also looks at the destination register and control bits held in the two pipeline registers that follow decode. From these it drives three signals: a program-counter write enable, a write enable for the fetch/decode register, and a bubble select. The bubble select clears every control field written into the decode/execute register.

Two kinds of hazard are covered. The first is a load followed at once by an instruction that uses the loaded register. The second applies because branches compare their operands in decode. A branch must also wait for an operand that an ALU instruction one slot ahead has not yet produced, or that a load one or two slots ahead has not yet returned. All outputs are combinational from the current pipeline-register contents and act at the next clock edge. While a stall holds, the instruction in decode is decoded again and the next instruction is fetched again. A parameter removes the branch rules for pipelines that resolve branches later.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the execute-stage entry has memory read set and its destination register is nonzero and equal to the decode instruction's rs or rt, a stall is raised, whether or not the decode instruction is a branch.
- R2: During a stall, pc_write_en and ifid_write_en are 0 and idex_bubble is 1. Outside a stall, pc_write_en and ifid_write_en are 1 and idex_bubble is 0.
- R3: With no matching producer in either stage, no stall is raised.
- R4: A destination register number of 0 never causes a stall, in any rule.
- R5: When the decode instruction is a branch (id_is_branch = 1) and the execute-stage entry has register write set and a nonzero destination equal to rs or rt, a stall is raised.
- R6: When the decode instruction is a branch and the memory-stage entry has both memory read and register write set and a nonzero destination equal to rs or rt, a stall is raised. With memory read alone, this rule does not apply.
- R7: A branch that compares the register loaded by the immediately preceding load spends exactly two cycles stalled in decode. A branch that compares a register written by a load two instructions earlier spends exactly one.
- R8: A branch whose operand comes only from the second or third preceding ALU instruction is not stalled.
- R9: A non-branch instruction is not stalled by an execute-stage ALU producer or by a memory-stage load.
- R10: A non-branch instruction that uses the result of the immediately preceding load spends exactly one cycle stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_is_branch | input | 1 | Decode instruction is a branch compared in decode |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rt | input | REG_AW | Second source register of the decode instruction |
| ex_mem_read | input | 1 | Execute-stage entry reads data memory (load) |
| ex_reg_write | input | 1 | Execute-stage entry writes a register |
| ex_dst | input | REG_AW | Execute-stage destination register |
| mem_mem_read | input | 1 | Memory-stage entry reads data memory |
| mem_reg_write | input | 1 | Memory-stage entry writes a register |
| mem_dst | input | REG_AW | Memory-stage destination register |
| pc_write_en | output | 1 | Program counter may advance |
| ifid_write_en | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Clear control fields entering execute |

## Verification
The bench builds the block with REG_AW = 5 and BRANCH_IN_DECODE = 1. This makes all three stall rules active over a full 32-entry register space, so register 0 and high register numbers can both be exercised. A vector table covers single-cycle decisions. A small pipeline model in the bench then feeds short instruction streams through the unit and counts stall cycles. This shows the two-cycle branch-after-load case emerging from two successive single-cycle decisions without any internal state.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Reason the front end is held in the current cycle, highest priority first.
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_LOADUSE = 2'd1,
    CAUSE_BR_EX   = 2'd2,
    CAUSE_BR_MEM  = 2'd3
  } hz_cause_e;
endpackage

// File: rtl/hz_reg_match.sv
module hz_reg_match #(
  parameter int AW = 5
) (
  input  logic          valid,
  input  logic [AW-1:0] dst,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;
  logic live;
  assign live = valid && (dst != ZERO_REG);
  assign hit  = live && ((dst == src_a) || (dst == src_b));
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int AW = 5
) (
  input  logic          ex_mem_read,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  output logic          stall
);
  hz_reg_match #(.AW(AW)) u_match (
    .valid (ex_mem_read),
    .dst   (ex_dst),
    .src_a (id_rs),
    .src_b (id_rt),
    .hit   (stall)
  );
endmodule

// File: rtl/hz_branch_chk.sv
module hz_branch_chk #(
  parameter int AW = 5
) (
  input  logic          is_branch,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          ex_reg_write,
  input  logic [AW-1:0] ex_dst,
  input  logic          mem_mem_read,
  input  logic          mem_reg_write,
  input  logic [AW-1:0] mem_dst,
  output logic          ex_stall,
  output logic          mem_stall
);
  logic ex_hit, mem_hit, mem_load;

  assign mem_load = mem_mem_read && mem_reg_write;

  // Producer one slot ahead: value not ready for a decode compare.
  hz_reg_match #(.AW(AW)) u_ex (
    .valid (ex_reg_write),
    .dst   (ex_dst),
    .src_a (id_rs),
    .src_b (id_rt),
    .hit   (ex_hit)
  );

  // Load two slots ahead: data still in the memory stage.
  hz_reg_match #(.AW(AW)) u_mem (
    .valid (mem_load),
    .dst   (mem_dst),
    .src_a (id_rs),
    .src_b (id_rt),
    .hit   (mem_hit)
  );

  assign ex_stall  = is_branch && ex_hit;
  assign mem_stall = is_branch && mem_hit;
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_AW           = 5,
  parameter bit BRANCH_IN_DECODE = 1'b1
) (
  input  logic              id_is_branch,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              ex_mem_read,
  input  logic              ex_reg_write,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_mem_read,
  input  logic              mem_reg_write,
  input  logic [REG_AW-1:0] mem_dst,
  output logic              pc_write_en,
  output logic              ifid_write_en,
  output logic              idex_bubble
);
  logic      lu_stall;
  logic      br_ex_stall;
  logic      br_mem_stall;
  hz_cause_e cause;

  hz_loaduse #(.AW(REG_AW)) u_loaduse (
    .ex_mem_read (ex_mem_read),
    .ex_dst      (ex_dst),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .stall       (lu_stall)
  );

  generate
    if (BRANCH_IN_DECODE) begin : g_branch
      hz_branch_chk #(.AW(REG_AW)) u_branch (
        .is_branch     (id_is_branch),
        .id_rs         (id_rs),
        .id_rt         (id_rt),
        .ex_reg_write  (ex_reg_write),
        .ex_dst        (ex_dst),
        .mem_mem_read  (mem_mem_read),
        .mem_reg_write (mem_reg_write),
        .mem_dst       (mem_dst),
        .ex_stall      (br_ex_stall),
        .mem_stall     (br_mem_stall)
      );
    end else begin : g_no_branch
      assign br_ex_stall  = 1'b0;
      assign br_mem_stall = 1'b0;
    end
  endgenerate

  always_comb begin
    if (lu_stall)          cause = CAUSE_LOADUSE;
    else if (br_ex_stall)  cause = CAUSE_BR_EX;
    else if (br_mem_stall) cause = CAUSE_BR_MEM;
    else                   cause = CAUSE_NONE;
  end

  assign idex_bubble   = (cause != CAUSE_NONE);
  assign pc_write_en   = (cause == CAUSE_NONE);
  assign ifid_write_en = (cause == CAUSE_NONE);
endmodule

// File: rtl/hazard_stall_chk.sv
module hazard_stall_chk #(
  parameter int AW = 5,
  parameter bit BR = 1'b1
) (
  input logic          id_is_branch,
  input logic [AW-1:0] id_rs,
  input logic [AW-1:0] id_rt,
  input logic          ex_mem_read,
  input logic          ex_reg_write,
  input logic [AW-1:0] ex_dst,
  input logic          mem_mem_read,
  input logic          mem_reg_write,
  input logic [AW-1:0] mem_dst,
  input logic          pc_write_en,
  input logic          ifid_write_en,
  input logic          idex_bubble
);
  logic ex_eq, mem_eq;
  assign ex_eq  = (ex_dst != '0) && (ex_dst == id_rs || ex_dst == id_rt);
  assign mem_eq = (mem_dst != '0) && (mem_dst == id_rs || mem_dst == id_rt);

  always_comb begin
    // R2
    stall_triplet_chk: assert ((pc_write_en == ifid_write_en) && (idex_bubble != pc_write_en))
      else $error("stall outputs disagree");
    if (ex_mem_read && ex_eq) begin
      // R1
      loaduse_stall_chk: assert (idex_bubble) else $error("load-use not stalled");
    end
    if (ex_dst == '0 && mem_dst == '0) begin
      // R4
      zero_reg_chk: assert (!idex_bubble) else $error("register zero caused stall");
    end
    if (BR && id_is_branch && ex_reg_write && ex_eq) begin
      // R5
      br_ex_stall_chk: assert (idex_bubble) else $error("branch vs execute producer not stalled");
    end
    if (BR && id_is_branch && mem_mem_read && mem_reg_write && mem_eq) begin
      // R6
      br_mem_stall_chk: assert (idex_bubble) else $error("branch vs memory-stage load not stalled");
    end
    if (!id_is_branch && !ex_mem_read) begin
      // R9
      nonbranch_free_chk: assert (!idex_bubble) else $error("non-branch stalled without load");
    end
    if (!(ex_mem_read && ex_eq) && !(ex_reg_write && ex_eq) && !(mem_mem_read && mem_reg_write && mem_eq)) begin
      // R3
      no_producer_chk: assert (!idex_bubble) else $error("stall without producer match");
    end
  end
endmodule

bind hazard_stall_unit hazard_stall_chk #(.AW(REG_AW), .BR(BRANCH_IN_DECODE)) u_chk (
  .id_is_branch  (id_is_branch),
  .id_rs         (id_rs),
  .id_rt         (id_rt),
  .ex_mem_read   (ex_mem_read),
  .ex_reg_write  (ex_reg_write),
  .ex_dst        (ex_dst),
  .mem_mem_read  (mem_mem_read),
  .mem_reg_write (mem_reg_write),
  .mem_dst       (mem_dst),
  .pc_write_en   (pc_write_en),
  .ifid_write_en (ifid_write_en),
  .idex_bubble   (idex_bubble)
);

// File: tb/tb_hazard_stall_unit.sv
`timescale 1ns/1ps
module tb_hazard_stall_unit;
  localparam int AW = 5;
  localparam int NV = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          id_is_branch;
  logic [AW-1:0] id_rs, id_rt, ex_dst, mem_dst;
  logic          ex_mem_read, ex_reg_write, mem_mem_read, mem_reg_write;
  logic          pc_write_en, ifid_write_en, idex_bubble;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hazard_stall_unit #(.REG_AW(AW), .BRANCH_IN_DECODE(1'b1)) dut (
    .id_is_branch (id_is_branch),
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .ex_mem_read  (ex_mem_read),
    .ex_reg_write (ex_reg_write),
    .ex_dst       (ex_dst),
    .mem_mem_read (mem_mem_read),
    .mem_reg_write(mem_reg_write),
    .mem_dst      (mem_dst),
    .pc_write_en  (pc_write_en),
    .ifid_write_en(ifid_write_en),
    .idex_bubble  (idex_bubble)
  );

  // {req[3:0], br, rs, rt, exrd, exwr, exdst, mmrd, mmwr, mmdst, exp_stall}
  localparam logic [29:0] VEC [NV] = '{
    {4'd3,  1'b0, 5'd3, 5'd5, 1'b1, 1'b1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0}, // R3 no match
    {4'd1,  1'b0, 5'd2, 5'd5, 1'b1, 1'b1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b1}, // R1 rs
    {4'd1,  1'b0, 5'd4, 5'd2, 1'b1, 1'b1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b1}, // R1 rt
    {4'd4,  1'b0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0}, // R4 load to r0
    {4'd9,  1'b0, 5'd2, 5'd7, 1'b0, 1'b1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0}, // R9 ALU ahead
    {4'd9,  1'b0, 5'd2, 5'd7, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd2, 1'b0}, // R9 load two ahead
    {4'd5,  1'b1, 5'd2, 5'd7, 1'b0, 1'b1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b1}, // R5
    {4'd7,  1'b1, 5'd7, 5'd2, 1'b1, 1'b1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b1}, // R7 load just ahead
    {4'd6,  1'b1, 5'd2, 5'd7, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd2, 1'b1}, // R6
    {4'd8,  1'b1, 5'd2, 5'd7, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd2, 1'b0}, // R8 ALU two ahead
    {4'd6,  1'b1, 5'd2, 5'd7, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd2, 1'b0}, // R6 read without write
    {4'd4,  1'b1, 5'd0, 5'd7, 1'b0, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0}, // R4 branch r0
    {4'd3,  1'b1, 5'd3, 5'd4, 1'b0, 1'b1, 5'd9, 1'b0, 1'b1, 5'd5, 1'b0}  // R3 branch no match
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pc_we,ifid_we,bubble} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_count(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: stall cycles actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Instruction word: {kind[1:0], dst, rs, rt}; kind 0=nop 1=alu 2=load 3=branch
  function automatic logic [16:0] i_alu(input int d, input int s, input int t);
    return {2'd1, 5'(d), 5'(s), 5'(t)};
  endfunction
  function automatic logic [16:0] i_ld(input int d, input int base);
    return {2'd2, 5'(d), 5'(base), 5'(d)};
  endfunction
  function automatic logic [16:0] i_br(input int s, input int t);
    return {2'd3, 5'd0, 5'(s), 5'(t)};
  endfunction
  localparam logic [16:0] I_NOP = 17'd0;

  // Small in-order pipeline model driving the unit; counts stalled cycles.
  task automatic run_stream(input logic [16:0] p0, input logic [16:0] p1,
                            input logic [16:0] p2, input logic [16:0] p3,
                            input string req, input int exp);
    logic [16:0] prog [4];
    logic [16:0] ifid;
    logic [6:0]  idex, exmem; // {memrd, regwr, dst}
    int pc = 0;
    int stalls = 0;
    prog[0] = p0; prog[1] = p1; prog[2] = p2; prog[3] = p3;
    ifid = I_NOP; idex = '0; exmem = '0;
    for (int cyc = 0; cyc < 12; cyc++) begin
      @(negedge clk);
      if (cyc > 0 && idex_bubble) stalls++;
      if (cyc > 0) begin
        exmem = idex;
        if (!idex_bubble) begin
          idex = {ifid[16:15] == 2'd2, ifid[16:15] == 2'd1 || ifid[16:15] == 2'd2, ifid[14:10]};
          ifid = (pc < 4) ? prog[pc] : I_NOP;
          pc++;
        end else begin
          idex = '0;
        end
      end
      id_is_branch  = (ifid[16:15] == 2'd3);
      id_rs         = ifid[9:5];
      id_rt         = ifid[4:0];
      ex_mem_read   = idex[6];
      ex_reg_write  = idex[5];
      ex_dst        = idex[4:0];
      mem_mem_read  = exmem[6];
      mem_reg_write = exmem[5];
      mem_dst       = exmem[4:0];
    end
    check_count(req, stalls, exp);
  endtask

  task automatic drive_all(input logic [29:0] v);
    id_is_branch  = v[25];
    id_rs         = v[24:20];
    id_rt         = v[19:15];
    ex_mem_read   = v[14];
    ex_reg_write  = v[13];
    ex_dst        = v[12:8];
    mem_mem_read  = v[7];
    mem_reg_write = v[6];
    mem_dst       = v[5:1];
  endtask

  initial begin
    drive_all('0);
    @(negedge clk);
    // R3 / R2 idle pipeline: nothing held
    check("R3 idle", {pc_write_en, ifid_write_en, idex_bubble}, 3'b110);

    for (int k = 0; k < NV; k++) begin
      drive_all(VEC[k]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d (R2 outputs)", VEC[k][29:26], k),
            {pc_write_en, ifid_write_en, idex_bubble},
            VEC[k][0] ? 3'b001 : 3'b110);
    end

    // R10 / R1 load then dependent ALU: one stall
    run_stream(i_ld(2, 3), i_alu(12, 2, 5), I_NOP, I_NOP, "R10 load-use", 1);
    // R7 load then dependent branch: two stalls
    run_stream(i_ld(2, 3), i_br(2, 0), I_NOP, I_NOP, "R7 load-branch", 2);
    // R5 ALU then dependent branch: one stall
    run_stream(i_alu(1, 2, 3), i_br(1, 4), I_NOP, I_NOP, "R5 alu-branch", 1);
    // R7 / R6 load two ahead of branch: one stall
    run_stream(i_ld(1, 3), i_alu(9, 5, 6), i_br(1, 4), I_NOP, "R7 load-x-branch", 1);
    // R8 ALU second and third ahead: no stall
    run_stream(i_alu(1, 2, 3), i_alu(9, 5, 6), i_br(1, 3), I_NOP, "R8 alu-x-branch", 0);
    run_stream(i_alu(1, 2, 3), i_alu(9, 5, 6), i_alu(10, 5, 6), i_br(1, 3), "R8 alu-x-x-branch", 0);
    // R9 non-branch after forwardable producers: no stall
    run_stream(i_ld(2, 3), i_alu(9, 5, 6), i_alu(11, 2, 7), I_NOP, "R9 load-x-use", 0);
    run_stream(i_alu(3, 4, 5), i_alu(8, 3, 3), I_NOP, I_NOP, "R9 alu-use", 0);
    // R4 load into register zero then branch on it
    run_stream(i_ld(0, 3), i_br(0, 0), I_NOP, I_NOP, "R4 zero-dst", 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule